// File: doc/BRIEF.md
# Dual-Port Boot Control Register

This block is an 8-bit control and status register shared by the CPU and a JTAG test access port. It holds a 2-bit programming-source select field and a system-program-enable bit. Each of them exists twice: one copy the CPU writes over its register bus, and one copy loaded through the JTAG programming buffer write port. A CPU read returns the bitwise OR of the two copies. A transfer-complete status input appears in bit 0 of the read data.

The combined enable bit drives the boot outputs. When it is clear, the boot address is 0000h, the application entry point. When it is set, the boot address is the boot loader entry and the programming-interface select goes out to the loader. A CPU write clears the JTAG copy of the source-select field. The reset-on-disconnect input clears the JTAG copy of the enable bit. Power-on reset and test-logic-reset clear both copies of every control bit.

Top module: `boot_ctl_reg`

## Requirements
- R1: After power-on reset (rst_ni low), the register reads 00h when txc_i is low, boot_ldr_o is 0, boot_addr_o is 0 and prog_if_o is 0.
- R2: Read data layout: bits 7:4 read 0, bits 3:2 are the select field, bit 1 is the enable bit and bit 0 is txc_i. Writes to bits 7:4 and bit 0 have no effect.
- R3: Read bits 3:2 equal the bitwise OR of the CPU select copy and the JTAG select copy.
- R4: Read bit 1 equals the OR of the CPU enable copy and the JTAG enable copy.
- R5: A CPU write decodes at module 02h, index 1Bh. It loads the CPU copies from wdata bits 3:1 and clears the JTAG select copy, both visible on the next cycle. The JTAG enable copy is unchanged.
- R6: rod_i high at a clock edge clears the JTAG enable copy. It also wins over a JTAG buffer write in the same cycle. The CPU enable copy is unaffected.
- R7: tlr_i high at a clock edge clears both copies of the select and enable bits.
- R8: boot_ldr_o equals the combined enable bit. boot_addr_o is 0 when that bit is 0 and LOADER_ADDR when it is 1.
- R9: prog_if_o equals the combined select field while the combined enable bit is 1, and is 0 otherwise.
- R10: When a CPU write and a JTAG buffer write occur in the same cycle, the JTAG select copy ends at 0 and the JTAG enable copy takes the JTAG value.
- R11: A CPU write to any other module or index changes no state, and the read data at any other address is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| tlr_i | input | 1 | Test-logic-reset, synchronous clear of control bits |
| cpu_mod_i | input | MOD_W | CPU register bus module address |
| cpu_idx_i | input | IDX_W | CPU register bus index address |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data (combinational on the address) |
| txc_i | input | 1 | Transfer-complete status |
| jtag_we_i | input | 1 | JTAG programming buffer write strobe |
| jtag_pss_i | input | 2 | JTAG select value |
| jtag_spe_i | input | 1 | JTAG enable value |
| rod_i | input | 1 | Reset-on-disconnect event |
| boot_ldr_o | output | 1 | Boot loader selected |
| boot_addr_o | output | ADDR_W | Reset vector address |
| prog_if_o | output | 2 | Programming interface select, gated by enable |

## Verification
The hard cases are the ones where the two copies interact within one cycle. A CPU write can coincide with a JTAG buffer write, and a reset-on-disconnect can coincide with a JTAG write of the enable bit. The bench drives these pulses in the same cycle. Each JTAG copy is observed alone by writing zero to the CPU copies and reading the OR back. The read then shows whether the JTAG select copy was cleared while the JTAG enable copy survived.

// File: rtl/boot_ctl_pkg.sv
package boot_ctl_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned PSS_LSB = 2;
  localparam int unsigned PSS_W   = 2;
  localparam int unsigned SPE_BIT = 1;
  localparam int unsigned TXC_BIT = 0;

  typedef struct packed {
    logic [PSS_W-1:0] pss;
    logic             spe;
  } ctl_t;
endpackage

// File: rtl/boot_ctl_cpu_reg.sv
module boot_ctl_cpu_reg
  import boot_ctl_pkg::*;
#(
  parameter int unsigned MOD_W = 4,
  parameter int unsigned IDX_W = 5,
  parameter logic [MOD_W-1:0] MOD_ADDR = 4'h2,
  parameter logic [IDX_W-1:0] IDX_ADDR = 5'h1B
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tlr_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             hit_o,
  output logic             wr_o,
  output ctl_t             cpu_q_o
);
  ctl_t cpu_q;

  assign hit_o = (mod_i == MOD_ADDR) && (idx_i == IDX_ADDR);
  assign wr_o  = hit_o && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_q <= '0;
    end else if (tlr_i) begin
      cpu_q <= '0;
    end else if (wr_o) begin
      cpu_q.pss <= wdata_i[PSS_LSB +: PSS_W];
      cpu_q.spe <= wdata_i[SPE_BIT];
    end
  end

  assign cpu_q_o = cpu_q;
endmodule

// File: rtl/boot_ctl_jtag_buf.sv
module boot_ctl_jtag_buf
  import boot_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tlr_i,
  input  logic             jtag_we_i,
  input  logic [PSS_W-1:0] jtag_pss_i,
  input  logic             jtag_spe_i,
  input  logic             rod_i,
  input  logic             cpu_wr_i,
  output ctl_t             jtag_q_o
);
  ctl_t jtag_q, jtag_d;

  // cpu clear applied after jtag load; rod wins over jtag spe load
  always_comb begin
    jtag_d = jtag_q;
    if (jtag_we_i) begin
      jtag_d.pss = jtag_pss_i;
      jtag_d.spe = jtag_spe_i;
    end
    if (cpu_wr_i) jtag_d.pss = '0;
    if (rod_i)    jtag_d.spe = 1'b0;
    if (tlr_i)    jtag_d     = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) jtag_q <= '0;
    else         jtag_q <= jtag_d;
  end

  assign jtag_q_o = jtag_q;
endmodule

// File: rtl/boot_ctl_vec.sv
module boot_ctl_vec
  import boot_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LOADER_ADDR = 16'h8000
) (
  input  ctl_t              ctl_i,
  output logic              boot_ldr_o,
  output logic [ADDR_W-1:0] boot_addr_o,
  output logic [PSS_W-1:0]  prog_if_o
);
  assign boot_ldr_o  = ctl_i.spe;
  assign boot_addr_o = ctl_i.spe ? LOADER_ADDR : '0;
  assign prog_if_o   = ctl_i.spe ? ctl_i.pss : '0;
endmodule

// File: rtl/boot_ctl_reg.sv
module boot_ctl_reg
  import boot_ctl_pkg::*;
#(
  parameter int unsigned MOD_W  = 4,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned ADDR_W = 16,
  parameter logic [MOD_W-1:0]  MOD_ADDR    = 4'h2,
  parameter logic [IDX_W-1:0]  IDX_ADDR    = 5'h1B,
  parameter logic [ADDR_W-1:0] LOADER_ADDR = 16'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tlr_i,
  input  logic [MOD_W-1:0]  cpu_mod_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  input  logic              cpu_we_i,
  input  logic [7:0]        cpu_wdata_i,
  output logic [7:0]        cpu_rdata_o,
  input  logic              txc_i,
  input  logic              jtag_we_i,
  input  logic [1:0]        jtag_pss_i,
  input  logic              jtag_spe_i,
  input  logic              rod_i,
  output logic              boot_ldr_o,
  output logic [ADDR_W-1:0] boot_addr_o,
  output logic [1:0]        prog_if_o
);
  logic hit, cpu_wr;
  ctl_t cpu_q, jtag_q, ctl;

  boot_ctl_cpu_reg #(
    .MOD_W(MOD_W), .IDX_W(IDX_W), .MOD_ADDR(MOD_ADDR), .IDX_ADDR(IDX_ADDR)
  ) u_cpu (
    .clk_i(clk_i), .rst_ni(rst_ni), .tlr_i(tlr_i),
    .mod_i(cpu_mod_i), .idx_i(cpu_idx_i), .we_i(cpu_we_i),
    .wdata_i(cpu_wdata_i), .hit_o(hit), .wr_o(cpu_wr), .cpu_q_o(cpu_q)
  );

  boot_ctl_jtag_buf u_jtag (
    .clk_i(clk_i), .rst_ni(rst_ni), .tlr_i(tlr_i),
    .jtag_we_i(jtag_we_i), .jtag_pss_i(jtag_pss_i), .jtag_spe_i(jtag_spe_i),
    .rod_i(rod_i), .cpu_wr_i(cpu_wr), .jtag_q_o(jtag_q)
  );

  assign ctl.pss = cpu_q.pss | jtag_q.pss;
  assign ctl.spe = cpu_q.spe | jtag_q.spe;

  always_comb begin
    cpu_rdata_o = '0;
    if (hit) begin
      cpu_rdata_o[PSS_LSB +: PSS_W] = ctl.pss;
      cpu_rdata_o[SPE_BIT]          = ctl.spe;
      cpu_rdata_o[TXC_BIT]          = txc_i;
    end
  end

  boot_ctl_vec #(.ADDR_W(ADDR_W), .LOADER_ADDR(LOADER_ADDR)) u_vec (
    .ctl_i(ctl), .boot_ldr_o(boot_ldr_o), .boot_addr_o(boot_addr_o),
    .prog_if_o(prog_if_o)
  );
endmodule

// File: rtl/boot_ctl_reg_chk.sv
module boot_ctl_reg_chk
  import boot_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LOADER_ADDR = 16'h8000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tlr_i,
  input logic              cpu_wr,
  input logic              rod_i,
  input logic              jtag_we_i,
  input logic              jtag_spe_i,
  input ctl_t              cpu_q,
  input ctl_t              jtag_q,
  input logic              boot_ldr_o,
  input logic [ADDR_W-1:0] boot_addr_o,
  input logic [1:0]        prog_if_o
);
  AST_CPU_WR_CLR_JPSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr |=> jtag_q.pss == '0); // R5
  AST_ROD_CLR_JSPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rod_i |=> !jtag_q.spe); // R6
  AST_TLR_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlr_i |=> (cpu_q == '0) && (jtag_q == '0)); // R7
  AST_BOOT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_addr_o == (boot_ldr_o ? LOADER_ADDR : '0)); // R8
  AST_PROG_IF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_ldr_o |-> prog_if_o == '0); // R9
  AST_SAME_CYC_JSPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr && jtag_we_i && !rod_i && !tlr_i) |=> jtag_q.spe == $past(jtag_spe_i)); // R10
  AST_CPU_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_wr && !tlr_i) |=> $stable(cpu_q)); // R11
endmodule

bind boot_ctl_reg boot_ctl_reg_chk #(.ADDR_W(ADDR_W), .LOADER_ADDR(LOADER_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tlr_i(tlr_i), .cpu_wr(cpu_wr), .rod_i(rod_i),
  .jtag_we_i(jtag_we_i), .jtag_spe_i(jtag_spe_i), .cpu_q(cpu_q), .jtag_q(jtag_q),
  .boot_ldr_o(boot_ldr_o), .boot_addr_o(boot_addr_o), .prog_if_o(prog_if_o)
);

// File: tb/boot_ctl_reg_tb_top.sv
module boot_ctl_reg_tb_top;
  localparam logic [15:0] LDR = 16'h8000;

  logic clk = 1'b0, rst_n = 1'b0, tlr = 1'b0;
  logic [3:0] mod = 4'h2;
  logic [4:0] idx = 5'h1B;
  logic we = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic txc = 1'b0, jwe = 1'b0, jspe = 1'b0, rod = 1'b0;
  logic [1:0] jpss = '0, pif;
  logic ldr;
  logic [15:0] baddr;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  boot_ctl_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tlr_i(tlr), .cpu_mod_i(mod), .cpu_idx_i(idx),
    .cpu_we_i(we), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .txc_i(txc),
    .jtag_we_i(jwe), .jtag_pss_i(jpss), .jtag_spe_i(jspe), .rod_i(rod),
    .boot_ldr_o(ldr), .boot_addr_o(baddr), .prog_if_o(pif)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, one edge, return at next negedge
  task automatic step();
    @(posedge clk); @(negedge clk);
    we = 0; jwe = 0; rod = 0; tlr = 0;
  endtask

  task automatic cpu_wr(logic [7:0] d);
    mod = 4'h2; idx = 5'h1B; wdata = d; we = 1; step();
  endtask

  task automatic jtag_wr(logic [1:0] p, logic s);
    jpss = p; jspe = s; jwe = 1; step();
  endtask

  task automatic rd(string req, logic [7:0] exp);
    mod = 4'h2; idx = 5'h1B; #1; chk(req, rdata, exp);
  endtask

  task automatic t_reset();
    rd("R1", 8'h00); chk("R1", ldr, 0); chk("R1", baddr, 0); chk("R1", pif, 0);
  endtask

  task automatic t_layout();
    cpu_wr(8'hFF); rd("R2", 8'h0E);
    txc = 1; rd("R2", 8'h0F); txc = 0;
    chk("R8", ldr, 1); chk("R8", baddr, LDR); chk("R9", pif, 2'b11);
    cpu_wr(8'h00); rd("R2", 8'h00);
  endtask

  task automatic t_or();
    jtag_wr(2'b01, 1'b0); rd("R3", 8'h04);
    chk("R9", pif, 2'b00); chk("R8", baddr, 16'h0);
    step(); // idle cycle
    mod = 4'h2; idx = 5'h1B; wdata = 8'h0A; we = 1; step(); // cpu pss=10 spe=1, clears jtag pss
    rd("R3", 8'h0A);
    jtag_wr(2'b01, 1'b0); rd("R3", 8'h0E); chk("R9", pif, 2'b11);
    cpu_wr(8'h00); jtag_wr(2'b00, 1'b1); rd("R4", 8'h02);
    chk("R8", ldr, 1); chk("R9", pif, 2'b00);
  endtask

  task automatic t_cpu_clr();
    jtag_wr(2'b11, 1'b1); rd("R5", 8'h0E);
    cpu_wr(8'h00); rd("R5", 8'h02); // jtag pss cleared, jtag spe kept
  endtask

  task automatic t_rod();
    cpu_wr(8'h02); rod = 1; step(); rd("R6", 8'h02); // cpu spe kept
    cpu_wr(8'h00); rd("R6", 8'h00);
    jpss = 2'b00; jspe = 1; jwe = 1; rod = 1; step(); rd("R6", 8'h00);
  endtask

  task automatic t_same_cycle();
    jpss = 2'b11; jspe = 1; jwe = 1; mod = 4'h2; idx = 5'h1B; wdata = 8'h00; we = 1;
    step(); rd("R10", 8'h02);
    rod = 1; step(); rd("R10", 8'h00);
  endtask

  task automatic t_tlr();
    cpu_wr(8'h06); jtag_wr(2'b10, 1'b1); rd("R7", 8'h0E);
    tlr = 1; step(); rd("R7", 8'h00); chk("R7", ldr, 0);
  endtask

  task automatic t_other_addr();
    mod = 4'h3; idx = 5'h1B; wdata = 8'h0E; we = 1; step();
    mod = 4'h2; idx = 5'h1A; wdata = 8'h0E; we = 1; step();
    rd("R11", 8'h00);
    cpu_wr(8'h0C); jtag_wr(2'b00, 1'b1);
    mod = 4'h2; idx = 5'h1C; #1; chk("R11", rdata, 8'h00);
    rd("R11", 8'h0E);
  endtask

  initial begin
    #20; @(negedge clk); rst_n = 1; @(negedge clk);
    t_reset();
    t_layout();
    t_or();
    tlr = 1; step();
    t_cpu_clr();
    tlr = 1; step();
    t_rod();
    t_same_cycle();
    t_tlr();
    t_other_addr();
    rst_n = 0; #1; rd("R1", 8'h00); chk("R1", baddr, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule